// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a pipelined synchronous burst SRAM with a 32-bit data word and a word depth set by a parameter. Every control input except the output enable is taken at the rising clock edge. A cycle with the address strobe low either opens a burst at the address on the bus or deselects the part. A cycle with the strobe high carries an open burst on at its internal burst address.

The burst address moves only through its two lowest bits, so a burst wraps inside an aligned group of four words. Writes take their data in the same cycle as their address, and four active-low lane enables mask them byte by byte. Reads go through an output register, so a word comes out in the cycle after its address.

The data output is a flag and data pair, `dq_oe` and `dq_out`, that stands in for a three-state pad. There is no back-pressure: when `dq_oe` is high, the word on `dq_out` is valid for that one cycle only, and the consumer has to take it then. `dq_out` is all zeros whenever `dq_oe` is low.

Top module: `sbsram_core`

## Requirements
- R1: A cycle with `cs_n`=0, `addr_stb_n`=0 and `we_n`=1 reads the word at `addr`. In the next cycle `dq_oe` is 1 (when `oe_n` is 0) and `dq_out` holds that word.
- R2: A cycle with `cs_n`=0, `addr_stb_n`=0 and `we_n`=0 writes `wdata` at `addr` in that same cycle. `dq_oe` is 0 in the following cycle.
- R3: `bw_n[0]` gates bits 7:0, `bw_n[1]` gates bits 15:8, `bw_n[2]` gates bits 23:16 and `bw_n[3]` gates bits 31:24, each active low. A lane whose enable is 1 keeps its old contents. All four enables at 0 write the whole word.
- R4: While a burst is open, a cycle with `addr_stb_n`=1 accesses the current burst address, reading when `we_n`=1 and writing when `we_n`=0. The burst address then steps on by one. `cs_n` has no effect in such a cycle.
- R5: The burst address following address A is A with its two low bits incremented modulo 4 and its upper bits unchanged. A burst started at a word whose low bits are 2 therefore visits low bits 2, 3, 0, 1.
- R6: A cycle with `cs_n`=1 and `addr_stb_n`=0 closes the burst, and `dq_oe` is 0 in the next cycle. Later cycles with `addr_stb_n`=1 neither write nor drive data until a new burst is started.
- R7: `oe_n`=1 forces `dq_oe` to 0 in the cycle in which it is applied, without a clock edge. `oe_n` has no effect on writes.
- R8: While reset is held, and after it is released, `dq_oe` is 0 and `dq_out` is 0 until a read happens. No burst is open after reset.
- R9: Only the low clog2(DEPTH) bits of `addr` select the word. Two addresses that differ only above those bits reach the same word.
- R10: `dq_out` is all zeros in every cycle in which `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip enable, active low |
| addr_stb_n | input | 1 | Address strobe, active low: opens a burst or deselects |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| bw_n | input | 4 | Byte lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| dq_out | output | 32 | Read data, zero when not driven |
| dq_oe | output | 1 | Read data valid and driven |

## Verification
The bench runs the model against a cycle-by-cycle behavioural reference and covers several input patterns:

- **Single starts.** Single reads and writes at scattered addresses show that read data takes exactly one cycle.
- **Burst starts.** Bursts started at low bits 1 and 2 separate a linear wrap inside the group of four from a plain increment that would carry into the upper bits.
- **Mixed bursts.** Bursts that mix reads and writes, or toggle `cs_n` in strobe-high cycles, show that each cycle's `we_n` is honoured and that `cs_n` is ignored there.
- **Masks and aliasing.** Partial byte masks, accesses after a deselect, reads with `oe_n` high, and addresses with high bits set separate the masking, closing, output-gating and aliasing rules from one another.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [2:0] {
    CYC_NOP,
    CYC_START_RD,
    CYC_START_WR,
    CYC_DESEL,
    CYC_CONT_RD,
    CYC_CONT_WR
  } cyc_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
(
  input  logic cs_n,
  input  logic addr_stb_n,
  input  logic we_n,
  input  logic live,
  output cyc_e kind
);
  always_comb begin
    if (!addr_stb_n) begin
      if (cs_n)      kind = CYC_DESEL;
      else if (we_n) kind = CYC_START_RD;
      else           kind = CYC_START_WR;
    end else if (live) begin
      kind = we_n ? CYC_CONT_RD : CYC_CONT_WR;
    end else begin
      kind = CYC_NOP;
    end
  end
endmodule

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
  import sbsram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          kind,
  input  logic [AW-1:0] ext_idx,
  output logic [AW-1:0] acc_idx,
  output logic          live
);
  logic [AW-1:0] ptr;
  logic          is_start, is_cont, armed;

  assign is_start = (kind == CYC_START_RD) || (kind == CYC_START_WR);
  assign is_cont  = (kind == CYC_CONT_RD)  || (kind == CYC_CONT_WR);
  assign acc_idx  = is_start ? ext_idx : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      live  <= 1'b0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (is_start) begin
        ptr  <= {ext_idx[AW-1:2], ext_idx[1:0] + 2'd1};
        live <= 1'b1;
      end else if (kind == CYC_DESEL) begin
        live <= 1'b0;
      end else if (is_cont) begin
        ptr <= {ptr[AW-1:2], ptr[1:0] + 2'd1};
      end
    end
  end

  // R5: the first burst-continue access follows the start address in the wrap order
  assert_wrap_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed) && is_cont && $past(is_start)) |->
      (acc_idx[1:0] == $past(ext_idx[1:0]) + 2'd1) &&
      (acc_idx[AW-1:2] == $past(ext_idx[AW-1:2])));

  // R6: a deselect cycle closes the burst
  assert_desel_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_DESEL) |=> !live);

  // R4: continue cycles never change the upper burst address bits
  assert_cont_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed) && is_cont && $past(is_cont)) |->
      (acc_idx[AW-1:2] == $past(acc_idx[AW-1:2])));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [AW-1:0]     acc_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  bw_n,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rd_vld_q
);
  logic [DATA_W-1:0] rd_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (acc_en && acc_wr && !bw_n[g])
        lane_mem[acc_idx] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = lane_mem[acc_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= acc_en && !acc_wr;
      if (acc_en && !acc_wr) rdata_q <= rd_word;
    end
  end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              addr_stb_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int AW = $clog2(DEPTH);

  cyc_e              kind;
  logic              live, acc_en, acc_wr, rd_vld_q;
  logic [AW-1:0]     acc_idx;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_hi;

  if (ADDR_W > AW) begin : g_hi
    assign unused_hi = ^addr[ADDR_W-1:AW];
  end else begin : g_nohi
    assign unused_hi = 1'b0;
  end

  sbsram_decode u_dec (
    .cs_n(cs_n), .addr_stb_n(addr_stb_n), .we_n(we_n), .live(live), .kind(kind)
  );

  sbsram_burst_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .kind(kind), .ext_idx(addr[AW-1:0]),
    .acc_idx(acc_idx), .live(live)
  );

  assign acc_en = (kind != CYC_NOP) && (kind != CYC_DESEL);
  assign acc_wr = (kind == CYC_START_WR) || (kind == CYC_CONT_WR);

  sbsram_array #(.DEPTH(DEPTH)) u_arr (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_idx(acc_idx), .wdata(wdata), .bw_n(bw_n),
    .rdata_q(rdata_q), .rd_vld_q(rd_vld_q)
  );

  assign dq_oe  = rd_vld_q && !oe_n;
  assign dq_out = dq_oe ? rdata_q : '0;

  // R1: a started read drives data in the next cycle whenever output enable is low
  assert_read_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_START_RD) |=> (dq_oe == !oe_n));

  // R2: a write cycle is followed by an undriven output
  assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !dq_oe);

  // R6: a deselect is followed by an undriven output
  assert_desel_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_DESEL) |=> !dq_oe);

  // R8: nothing is driven while reset is held
  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R8: assert (!dq_oe && dq_out == '0);
  end
endmodule

// File: tb/sim_sbsram_core.sv
`timescale 1ns/1ps
module sim_sbsram_core;
  localparam int DEPTH  = 1024;
  localparam int ADDR_W = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, addr_stb_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [3:0]  bw_n = 4'hF;
  logic [17:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] dq_out;
  logic        dq_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [31:0] ref_mem [int];
  bit          ref_live = 0;
  int          ref_cnt = 0;
  bit          exp_vld = 0;
  logic [31:0] exp_rd = '0;

  always #5 clk = ~clk;

  sbsram_core #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_stb_n(addr_stb_n),
    .we_n(we_n), .oe_n(oe_n), .bw_n(bw_n), .addr(addr), .wdata(wdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic int nxt(int a);
    return (a & ~3) | ((a + 1) & 3);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    bit on;
    on = exp_vld && !oe_n;
    chk({tag, " flag"}, {31'd0, dq_oe}, {31'd0, on});
    chk({tag, " data (R10 zero when off)"}, dq_out, on ? exp_rd : 32'd0);
  endtask

  // one clock: drive, predict, clock, compare
  task automatic step(string tag, bit c, bit s, bit w, bit o, logic [3:0] b,
                      logic [17:0] a, logic [31:0] d);
    bit doacc, wr;
    int idx;
    logic [31:0] old;
    cs_n = c; addr_stb_n = s; we_n = w; oe_n = o; bw_n = b; addr = a; wdata = d;
    doacc = 0; wr = !w; idx = 0;
    if (!s) begin
      if (c) ref_live = 0;
      else begin
        ref_live = 1; idx = int'(a) % DEPTH; ref_cnt = nxt(idx); doacc = 1;
      end
    end else if (ref_live) begin
      idx = ref_cnt; ref_cnt = nxt(ref_cnt); doacc = 1;
    end
    exp_vld = doacc && !wr;
    if (doacc && wr) begin
      old = ref_mem.exists(idx) ? ref_mem[idx] : 32'd0;
      for (int k = 0; k < 4; k++) if (!b[k]) old[k*8 +: 8] = d[k*8 +: 8];
      ref_mem[idx] = old;
    end else if (doacc) begin
      exp_rd = ref_mem[idx];
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr1(string tag, int a, logic [31:0] d, logic [3:0] b);
    step(tag, 0, 0, 0, 0, b, 18'(a), d);
  endtask

  task automatic rd1(string tag, int a);
    step(tag, 0, 0, 1, 0, 4'hF, 18'(a), 32'h0);
  endtask

  task automatic nop(string tag);
    step(tag, 1, 1, 1, 0, 4'hF, 18'h0, 32'h0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish (all requirements)");
      summary();
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 flag in reset", {31'd0, dq_oe}, 32'd0);
    chk("R8 data in reset", dq_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R8 after release");
    nop("R8 strobe high, no burst");

    // R2: fill words 0..15 with full-word writes
    for (int i = 0; i < 16; i++) wr1("R2 fill", i, 32'hA500_0000 + 32'(i * 32'h0101_0101), 4'h0);
    // R1: single reads
    rd1("R1 read 5", 5);
    rd1("R1 read 0", 0);
    nop("R1 drain");
    // R4, R5: read burst from 5 wraps 6,7,4
    rd1("R4 start 5", 5);
    for (int i = 0; i < 3; i++) step("R4 cont read", 0, 1, 1, 0, 4'hF, 18'h0, 32'h0);
    // R5: burst from low bits 2 visits 2,3,0,1 (cs_n toggled, ignored under R4)
    rd1("R5 start 10", 10);
    for (int i = 0; i < 4; i++) step("R5 wrap", i[0], 1, 1, 0, 4'hF, 18'h0, 32'h0);
    // R3: byte lanes
    wr1("R3 lane0", 8, 32'h1122_3344, 4'b1110);
    rd1("R3 readback lane0", 8);
    wr1("R3 lanes 3,1", 8, 32'hDEAD_BEEF, 4'b0101);
    rd1("R3 readback lanes", 8);
    nop("R3 drain");
    // R4: write burst with mixed reads, cs_n high ignored
    wr1("R4 write start 13", 13, 32'h0BAD_F00D, 4'h0);
    step("R4 cont write 14", 1, 1, 0, 0, 4'h0, 18'h0, 32'h1234_5678);
    step("R4 cont read 15", 0, 1, 1, 0, 4'hF, 18'h0, 32'h0);
    step("R4 cont write 12", 1, 1, 0, 0, 4'b0011, 18'h0, 32'hCAFE_0000);
    for (int i = 12; i < 16; i++) rd1("R4 readback", i);
    // R6: deselect closes, later strobe-high writes ignored
    rd1("R6 read 2", 2);
    step("R6 deselect", 1, 0, 1, 0, 4'hF, 18'h0, 32'h0);
    step("R6 ignored write", 0, 1, 0, 0, 4'h0, 18'h0, 32'hFFFF_FFFF);
    step("R6 ignored read", 0, 1, 1, 0, 4'hF, 18'h0, 32'h0);
    for (int i = 0; i < 4; i++) rd1("R6 words untouched", i);
    // R7: output enable gating and writes with oe_n high
    rd1("R7 read 7", 7);
    step("R7 oe high", 0, 0, 1, 1, 4'hF, 18'd6, 32'h0);
    step("R7 write with oe high", 0, 0, 0, 1, 4'h0, 18'd9, 32'h5555_AAAA);
    rd1("R7 readback 9", 9);
    oe_n = 1'b1; #1;
    chk("R7 async gate flag", {31'd0, dq_oe}, 32'd0);
    chk("R7 async gate data", dq_out, 32'd0);
    oe_n = 1'b0; #1;
    chk("R7 async release", dq_out, exp_rd);
    @(negedge clk);
    exp_vld = 0;
    // R9: high address bits ignored
    wr1("R9 alias write", 32'h403, 32'h7777_0003, 4'h0);
    rd1("R9 read low alias", 3);
    rd1("R9 read high alias", 32'h2_0003);
    nop("R9 drain");

    done = 1;
    summary();
    $finish;
  end
endmodule